// File: doc/BRIEF.md
# PCI Function Configuration Register File

This block holds the configuration registers for one to several PCI functions. It is placed behind a bus front end that has already decoded a configuration transaction into a function number, a dword index, byte enables and data. The block answers each request one cycle later with a response that carries read data, or a retry flag when the function is not yet ready.

Each function has a 256-byte space: 64 dword slots, addressed by a 6-bit dword index. Dwords 0 to 15 make up the standard header. From dword 16 upward the space is device specific, and the first `NUM_DEV` of those dwords are general read/write registers. The header holds a fixed identity, a Command/Status dword, class and revision, a header-type byte, one 32-bit memory BAR that can be size-probed, the subsystem identifiers and the interrupt line and pin. Each function's subsystem identifiers arrive through a one-shot preload port. Until that preload is accepted, the function answers every access with a retry. Every function has its own private copy of every writable bit.

Top module: `pcfg_target`

## Requirements
- R1: After reset every function is unloaded. An access to an unloaded, populated function gets a response with `rsp_retry`=1 and `rsp_rdata`=0, and a write to it changes nothing.
- R2: A preload for a function is accepted only when both `ld_svid` and `ld_sid` are nonzero. A preload with either field zero is ignored. After the first accepted preload the function is loaded, and later preloads to it are ignored. Dword 11 reads {sid[31:16], svid[15:0]} and cannot be changed by configuration writes.
- R3: Dword 0 reads {DEV_ID + function number, VEN_ID}, and dword 2 reads CLASS_REV. Writes to either dword are ignored.
- R4: Dword 1 is {status, command}. Command bits 1, 2, 6, 8 and 10 (mask 0x0546) are writable, all other command bits read 0, and the status half reads 0.
- R5: Dword 4 is a 32-bit memory BAR of 2^BAR_BITS bytes. Bits [31:BAR_BITS] are writable. The lower bits read 0: bit 0 = memory, bits 2:1 = 00 (anywhere in 32-bit space), bit 3 = not prefetchable. Writing all ones reads back ~(2^BAR_BITS-1). Any base, including bases above 1 MB, is kept.
- R6: Byte enables `req_be[k]` gate byte k (bits 8k+7:8k). A write changes only the enabled bytes of a writable register.
- R7: Every other dword (dwords 5–10, 12–14, and device-specific dwords at or beyond 16+NUM_DEV) reads 0. A write to one of them completes with `rsp_retry`=0, and its data is discarded.
- R8: Dwords 16 to 16+NUM_DEV-1 are full 32-bit read/write registers.
- R9: No writable bit is shared between functions. A write to one function leaves every register of every other function unchanged.
- R10: Dword 3 bits 23:16 read 0x80 when NUM_FN>1 (multifunction, header type 0), and 0x00 otherwise. Dword 15 reads {16'h0, INT_PIN, line}, and the line byte is read/write.
- R11: A function number at or above NUM_FN is unpopulated. It responds with `rsp_retry`=0 and `rsp_rdata`=0, and writes to it are discarded.
- R12: `rsp_valid` is 1 in the cycle after each cycle with `req_valid`=1, and 0 otherwise. Write responses carry `rsp_rdata`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_valid | input | 1 | Subsystem identifier preload strobe |
| ld_fn | input | FNW | Function targeted by the preload |
| ld_svid | input | 16 | Subsystem vendor identifier to preload |
| ld_sid | input | 16 | Subsystem identifier to preload |
| req_valid | input | 1 | Configuration request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_fn | input | FNW | Function number of the request |
| req_dw | input | 6 | Dword index within the 256-byte space |
| req_be | input | 4 | Byte enables for writes |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_retry | output | 1 | Function not yet loaded; the access had no effect |
| rsp_rdata | output | 32 | Read data |

## Verification
The bench builds the block with NUM_FN=3. This widens the function number to two bits and leaves slot 3 unpopulated, so the empty-slot behaviour of R11 can be reached at all. With three functions, the bench can also hold one function unloaded while two others are already live and being written. BAR_BITS=8 gives the smallest BAR, so size probing returns 0xFFFFFF00 and a single-byte write lands on the top byte of the base. NUM_DEV=4 places the first reserved device-specific dword at index 20, next to the last scratch dword.

// File: rtl/pcfg_target.sv
module pcfg_target #(
  parameter logic [15:0] VEN_ID    = 16'h1A2B,
  parameter logic [15:0] DEV_ID    = 16'h0100,
  parameter logic [31:0] CLASS_REV = 32'h0580_0001,
  parameter logic [7:0]  INT_PIN   = 8'h01,
  parameter int NUM_FN   = 2,
  parameter int BAR_BITS = 12,
  parameter int NUM_DEV  = 4,
  localparam int FNW = (NUM_FN > 1) ? $clog2(NUM_FN) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ld_valid,
  input  logic [FNW-1:0] ld_fn,
  input  logic [15:0]    ld_svid,
  input  logic [15:0]    ld_sid,
  input  logic           req_valid,
  input  logic           req_write,
  input  logic [FNW-1:0] req_fn,
  input  logic [5:0]     req_dw,
  input  logic [3:0]     req_be,
  input  logic [31:0]    req_wdata,
  output logic           rsp_valid,
  output logic           rsp_retry,
  output logic [31:0]    rsp_rdata
);
  localparam int          SLOTS    = 1 << FNW;
  localparam logic [15:0] CMD_MASK = 16'h0546;
  localparam logic [7:0]  HDR_TYPE = (NUM_FN > 1) ? 8'h80 : 8'h00;
  localparam logic [5:0]  DEV_BASE = 6'd16;

  logic [31:0] be_mask;
  assign be_mask = {{8{req_be[3]}}, {8{req_be[2]}}, {8{req_be[1]}}, {8{req_be[0]}}};

  logic [SLOTS-1:0]       pop, rdy;
  logic [SLOTS-1:0][31:0] rword;

  for (genvar f = 0; f < SLOTS; f++) begin : g_fn
    if (f < NUM_FN) begin : g_live
      logic                     ready;
      logic [15:0]              svid, sid, cmd;
      logic [31:BAR_BITS]       bar;
      logic [7:0]               intl;
      logic [NUM_DEV-1:0][31:0] scr;
      logic [31:0]              rd, nxt;
      logic                     wr, ld;

      assign wr  = req_valid && req_write && ready && (req_fn == FNW'(f));
      assign ld  = ld_valid && !ready && (ld_fn == FNW'(f)) && (ld_svid != 16'h0) && (ld_sid != 16'h0);
      assign nxt = (rd & ~be_mask) | (req_wdata & be_mask);

      always_comb begin
        rd = '0;
        case (req_dw)
          6'd0:  rd = {DEV_ID + 16'(f), VEN_ID};
          6'd1:  rd = {16'h0000, cmd};
          6'd2:  rd = CLASS_REV;
          6'd3:  rd = {8'h00, HDR_TYPE, 16'h0000};
          6'd4:  rd = {bar, {BAR_BITS{1'b0}}};
          6'd11: rd = {sid, svid};
          6'd15: rd = {16'h0000, INT_PIN, intl};
          default: begin
            for (int i = 0; i < NUM_DEV; i++)
              if (req_dw == DEV_BASE + 6'(i)) rd = scr[i];
          end
        endcase
      end

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          ready <= 1'b0;
          svid  <= '0;
          sid   <= '0;
          cmd   <= '0;
          bar   <= '0;
          intl  <= '0;
          scr   <= '0;
        end else begin
          if (ld) begin
            ready <= 1'b1;
            svid  <= ld_svid;
            sid   <= ld_sid;
          end
          if (wr) begin
            case (req_dw)
              6'd1:    cmd  <= nxt[15:0] & CMD_MASK;
              6'd4:    bar  <= nxt[31:BAR_BITS];
              6'd15:   intl <= nxt[7:0];
              default: begin
                for (int i = 0; i < NUM_DEV; i++)
                  if (req_dw == DEV_BASE + 6'(i)) scr[i] <= nxt;
              end
            endcase
          end
        end
      end

      assign pop[f]   = 1'b1;
      assign rdy[f]   = ready;
      assign rword[f] = rd;
    end else begin : g_hole
      assign pop[f]   = 1'b0;
      assign rdy[f]   = 1'b0;
      assign rword[f] = '0;
    end
  end

  logic live;
  assign live = pop[req_fn] && rdy[req_fn];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_retry <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_retry <= req_valid && pop[req_fn] && !rdy[req_fn];
      rsp_rdata <= (req_valid && !req_write && live) ? rword[req_fn] : '0;
    end
  end
endmodule

// File: rtl/pcfg_target_chk.sv
module pcfg_target_chk #(
  parameter int BAR_BITS = 12
) (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_write,
  input logic [5:0]  req_dw,
  input logic        rsp_valid,
  input logic        rsp_retry,
  input logic [31:0] rsp_rdata
);
  AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid); // R12
  AST_RSP_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(req_valid)); // R12
  AST_WRITE_RSP_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    $past(req_valid && req_write) |-> rsp_rdata == 32'h0); // R12
  AST_RETRY_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_retry |-> (rsp_valid && rsp_rdata == 32'h0)); // R1
  AST_BAR_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $past(req_valid && !req_write && req_dw == 6'd4) |-> rsp_rdata[BAR_BITS-1:0] == '0); // R5
  AST_RSVD_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $past(req_valid && !req_write && req_dw >= 6'd5 && req_dw <= 6'd10) |-> rsp_rdata == 32'h0); // R7
endmodule

bind pcfg_target pcfg_target_chk #(.BAR_BITS(BAR_BITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .req_dw(req_dw), .rsp_valid(rsp_valid), .rsp_retry(rsp_retry), .rsp_rdata(rsp_rdata)
);

// File: tb/sim_pcfg_target.sv
module sim_pcfg_target;
  localparam int NUM_FN = 3, BAR_BITS = 8, NUM_DEV = 4, FNW = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ld_valid = 1'b0;
  logic [FNW-1:0] ld_fn = '0;
  logic [15:0] ld_svid = '0, ld_sid = '0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [FNW-1:0] req_fn = '0;
  logic [5:0] req_dw = '0;
  logic [3:0] req_be = '0;
  logic [31:0] req_wdata = '0;
  logic rsp_valid, rsp_retry;
  logic [31:0] rsp_rdata;

  always #2 clk = ~clk;

  pcfg_target #(.NUM_FN(NUM_FN), .BAR_BITS(BAR_BITS), .NUM_DEV(NUM_DEV)) u0 (
    .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_fn(ld_fn), .ld_svid(ld_svid),
    .ld_sid(ld_sid), .req_valid(req_valid), .req_write(req_write), .req_fn(req_fn),
    .req_dw(req_dw), .req_be(req_be), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_retry(rsp_retry), .rsp_rdata(rsp_rdata));

  int checks = 0, errors = 0;
  logic [31:0] got;
  logic got_retry, got_valid;

  typedef struct packed {
    logic        w;
    logic [1:0]  fn;
    logic [5:0]  dw;
    logic [3:0]  be;
    logic [31:0] wd;
    logic [31:0] ex;
  } vec_t;

  localparam int NV = 38;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 2'd0, 6'd0,  4'hF, 32'h0,         32'h0100_1A2B}, // R3
    '{1'b0, 2'd1, 6'd0,  4'hF, 32'h0,         32'h0101_1A2B}, // R3
    '{1'b1, 2'd0, 6'd0,  4'hF, 32'hFFFF_FFFF, 32'h0},         // R12
    '{1'b0, 2'd0, 6'd0,  4'hF, 32'h0,         32'h0100_1A2B}, // R3
    '{1'b0, 2'd0, 6'd2,  4'hF, 32'h0,         32'h0580_0001}, // R3
    '{1'b0, 2'd0, 6'd3,  4'hF, 32'h0,         32'h0080_0000}, // R10
    '{1'b0, 2'd0, 6'd11, 4'hF, 32'h0,         32'h2222_1111}, // R2
    '{1'b0, 2'd1, 6'd11, 4'hF, 32'h0,         32'h4444_3333}, // R2
    '{1'b1, 2'd0, 6'd11, 4'hF, 32'hFFFF_FFFF, 32'h0},         // R2
    '{1'b0, 2'd0, 6'd11, 4'hF, 32'h0,         32'h2222_1111}, // R2
    '{1'b1, 2'd0, 6'd1,  4'hF, 32'hFFFF_FFFF, 32'h0},         // R4
    '{1'b0, 2'd0, 6'd1,  4'hF, 32'h0,         32'h0000_0546}, // R4
    '{1'b0, 2'd1, 6'd1,  4'hF, 32'h0,         32'h0},         // R9
    '{1'b1, 2'd0, 6'd4,  4'hF, 32'hFFFF_FFFF, 32'h0},         // R5
    '{1'b0, 2'd0, 6'd4,  4'hF, 32'h0,         32'hFFFF_FF00}, // R5
    '{1'b1, 2'd0, 6'd4,  4'hF, 32'h1234_5678, 32'h0},         // R5
    '{1'b0, 2'd0, 6'd4,  4'hF, 32'h0,         32'h1234_5600}, // R5
    '{1'b1, 2'd0, 6'd4,  4'h8, 32'hAB00_0000, 32'h0},         // R6
    '{1'b0, 2'd0, 6'd4,  4'hF, 32'h0,         32'hAB34_5600}, // R6
    '{1'b0, 2'd1, 6'd4,  4'hF, 32'h0,         32'h0},         // R9
    '{1'b1, 2'd0, 6'd15, 4'hF, 32'hFFFF_FFFF, 32'h0},         // R10
    '{1'b0, 2'd0, 6'd15, 4'hF, 32'h0,         32'h0000_01FF}, // R10
    '{1'b1, 2'd0, 6'd16, 4'h5, 32'hDEAD_BEEF, 32'h0},         // R6
    '{1'b0, 2'd0, 6'd16, 4'hF, 32'h0,         32'h00AD_00EF}, // R6
    '{1'b1, 2'd0, 6'd19, 4'hF, 32'hCAFE_F00D, 32'h0},         // R8
    '{1'b0, 2'd0, 6'd19, 4'hF, 32'h0,         32'hCAFE_F00D}, // R8
    '{1'b1, 2'd0, 6'd20, 4'hF, 32'h1234_5678, 32'h0},         // R7
    '{1'b0, 2'd0, 6'd20, 4'hF, 32'h0,         32'h0},         // R7
    '{1'b1, 2'd0, 6'd6,  4'hF, 32'hFFFF_FFFF, 32'h0},         // R7
    '{1'b0, 2'd0, 6'd6,  4'hF, 32'h0,         32'h0},         // R7
    '{1'b0, 2'd0, 6'd63, 4'hF, 32'h0,         32'h0},         // R7
    '{1'b0, 2'd1, 6'd19, 4'hF, 32'h0,         32'h0},         // R9
    '{1'b1, 2'd1, 6'd1,  4'h1, 32'hFFFF_FFFF, 32'h0},         // R6
    '{1'b0, 2'd1, 6'd1,  4'hF, 32'h0,         32'h0000_0046}, // R6
    '{1'b0, 2'd0, 6'd1,  4'hF, 32'h0,         32'h0000_0546}, // R9
    '{1'b1, 2'd3, 6'd16, 4'hF, 32'h1111_1111, 32'h0},         // R11
    '{1'b0, 2'd3, 6'd16, 4'hF, 32'h0,         32'h0},         // R11
    '{1'b0, 2'd3, 6'd0,  4'hF, 32'h0,         32'h0}          // R11
  };
  string vtag [NV] = '{"R3","R3","R12","R3","R3","R10","R2","R2","R2","R2",
                       "R4","R4","R9","R5","R5","R5","R5","R6","R6","R9",
                       "R10","R10","R6","R6","R8","R8","R7","R7","R7","R7",
                       "R7","R9","R6","R6","R9","R11","R11","R11"};

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  task automatic acc(input logic w, input logic [1:0] fn, input logic [5:0] dw,
                     input logic [3:0] be, input logic [31:0] wd);
    req_valid = 1'b1; req_write = w; req_fn = fn; req_dw = dw; req_be = be; req_wdata = wd;
    @(negedge clk);
    got = rsp_rdata; got_retry = rsp_retry; got_valid = rsp_valid;
    req_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic preload(input logic [1:0] fn, input logic [15:0] sv, input logic [15:0] si);
    ld_valid = 1'b1; ld_fn = fn; ld_svid = sv; ld_sid = si;
    @(negedge clk);
    ld_valid = 1'b0;
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R12 idle after reset", {31'h0, rsp_valid}, 32'h0);
    // R1: reset state is unloaded, accesses retry, writes ignored
    acc(1'b0, 2'd0, 6'd0, 4'hF, 32'h0);
    chk("R1 retry flag", {31'h0, got_retry}, 32'h1);
    chk("R1 retry data", got, 32'h0);
    chk("R12 response strobe", {31'h0, got_valid}, 32'h1);
    chk("R12 no strobe when idle", {31'h0, rsp_valid}, 32'h0);
    acc(1'b1, 2'd0, 6'd1, 4'hF, 32'hFFFF_FFFF);
    chk("R1 write retry", {31'h0, got_retry}, 32'h1);
    // R2: zero-field preloads are ignored
    preload(2'd0, 16'h0000, 16'h2222);
    preload(2'd0, 16'h1111, 16'h0000);
    acc(1'b0, 2'd0, 6'd11, 4'hF, 32'h0);
    chk("R2 zero preload ignored", {31'h0, got_retry}, 32'h1);
    preload(2'd0, 16'h1111, 16'h2222);
    preload(2'd1, 16'h3333, 16'h4444);
    acc(1'b0, 2'd0, 6'd1, 4'hF, 32'h0);
    chk("R1 write while unloaded discarded", got, 32'h0);

    for (int k = 0; k < NV; k++) begin
      acc(VEC[k].w, VEC[k].fn, VEC[k].dw, VEC[k].be, VEC[k].wd);
      chk(vtag[k], got, VEC[k].ex);
      chk({vtag[k], " retry"}, {31'h0, got_retry}, 32'h0);
    end

    // R1 / R2 / R9: function 2 still unloaded while others are live
    acc(1'b0, 2'd2, 6'd0, 4'hF, 32'h0);
    chk("R1 fn2 retry", {31'h0, got_retry}, 32'h1);
    preload(2'd2, 16'h5555, 16'h6666);
    preload(2'd2, 16'h7777, 16'h8888);
    acc(1'b0, 2'd2, 6'd11, 4'hF, 32'h0);
    chk("R2 first preload held", got, 32'h6666_5555);
    acc(1'b0, 2'd2, 6'd4, 4'hF, 32'h0);
    chk("R9 fn2 BAR untouched", got, 32'h0);
    acc(1'b0, 2'd2, 6'd0, 4'hF, 32'h0);
    chk("R3 fn2 device id", got, 32'h0102_1A2B);
    acc(1'b0, 2'd3, 6'd11, 4'hF, 32'h0);
    chk("R11 empty slot no retry", {31'h0, got_retry}, 32'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule